// File: doc/BRIEF.md
# Four-Beat Double-Rate Two-Port SRAM Core

This core holds 36-bit words in groups of four and moves data on both halves of a single clock. Each half-cycle beat appears as a pair of buses, one for the rising phase and one for the falling phase, so the whole design runs on one clock. A read port and a write port operate independently and share one address bus. The rising-phase half of that bus carries the read address. The falling-phase half carries the write address. Every access is a burst covering the four words of one group.

A write accepted in a cycle stores beats 0 and 1 in that cycle and beats 2 and 3 in the next cycle. Each beat has an active-low enable for each of its four 9-bit lanes. A read accepted in a cycle returns its four words during the second and third cycles after the command, two beats per cycle, with an output-enable flag raised. When no burst is being delivered, the flag is low and the data buses read zero. The number of groups is a parameter. Setting `ADDR_W` to 17 gives a 512K-word array, and the default is small.

Top module: `qdr_burst4_sram`

## Requirements
- R1: Both port selects (`rd_sel_n`, `wr_sel_n`) are active low and are sampled on the rising clock edge. A low select on an accepted edge starts a burst on that port, and a high select starts nothing.
- R2: A write accepted at edge k uses group address `addr_fall`. It stores `wdata_rise` into word 4g+0 and `wdata_fall` into word 4g+1 at edge k. It then stores the `wdata_rise` and `wdata_fall` presented at edge k+1 into words 4g+2 and 4g+3.
- R3: A write select at the edge right after an accepted write is ignored. That edge carries beats 2 and 3 of the running burst, so write commands are accepted at most every other cycle.
- R4: Byte-enable bit l of `bwe_rise_n` or `bwe_fall_n` writes bits 9l+8:9l of the beat on the same phase when it is 0. When it is 1, the stored lane keeps its old value. Lane 0 is bits 8:0 and lane 3 is bits 35:27.
- R5: A read accepted at edge k uses group address `addr_rise`. After edge k+1, words 4g+0 and 4g+1 appear on `rdata_rise` and `rdata_fall`. After edge k+2, words 4g+2 and 4g+3 appear. `rdata_valid` is 1 in both of those cycles.
- R6: A read select at the edge right after an accepted read is ignored.
- R7: A read returns the array as it stood before its command edge. Write beats stored on that same edge, or later, are not seen, even when both ports address the same group.
- R8: A burst in progress completes even if `rd_sel_n` goes high. After the last beat pair, `rdata_valid` falls on the next rising edge unless another read follows. While it is 0, both data buses are 0.
- R9: While the write port is deselected, its address, data and byte enables leave the array unchanged.
- R10: After reset, `rdata_valid` is 0, both read buses are 0 and neither port has a burst pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; both phases are carried as bus pairs |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_sel_n | input | 1 | Read port select, active low |
| wr_sel_n | input | 1 | Write port select, active low |
| addr_rise | input | ADDR_W | Shared address bus, rising phase (read group) |
| addr_fall | input | ADDR_W | Shared address bus, falling phase (write group) |
| wdata_rise | input | 36 | Write beat on rising phase |
| wdata_fall | input | 36 | Write beat on falling phase |
| bwe_rise_n | input | 4 | Active-low lane enables for rising beat |
| bwe_fall_n | input | 4 | Active-low lane enables for falling beat |
| rdata_rise | output | 36 | Read beat on rising phase |
| rdata_fall | output | 36 | Read beat on falling phase |
| rdata_valid | output | 1 | Output enable: read beats are being delivered |

## Verification
Full-lane fills followed by read-back of every group show whether bursts land at the right word offsets and on the right phase. Directed partial lane masks separate the lanes from each other. Selects held low over several cycles tell accepted commands from the ignored edges in between. A deselected write carrying junk data must leave the array intact. A read and a write aimed at the same group in one cycle tell old-data return apart from forwarding. A long run of random selects, addresses, data and masks, checked against a bench model, mixes overlapping read and write bursts.

// File: rtl/qdr_burst4_sram.sv
module qdr_burst4_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_sel_n,
  input  logic                      wr_sel_n,
  input  logic [ADDR_W-1:0]         addr_rise,
  input  logic [ADDR_W-1:0]         addr_fall,
  input  logic [LANES*LANE_W-1:0]   wdata_rise,
  input  logic [LANES*LANE_W-1:0]   wdata_fall,
  input  logic [LANES-1:0]          bwe_rise_n,
  input  logic [LANES-1:0]          bwe_fall_n,
  output logic [LANES*LANE_W-1:0]   rdata_rise,
  output logic [LANES*LANE_W-1:0]   rdata_fall,
  output logic                      rdata_valid
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int BEATS  = 4;
  localparam int WORDS  = (1 << ADDR_W) * BEATS;

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] snap [BEATS];
  logic [ADDR_W-1:0] wr_grp;
  logic              wr_busy, rd_busy, rd_tail;

  wire wr_go = !wr_sel_n && !wr_busy;
  wire rd_go = !rd_sel_n && !rd_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_busy <= 1'b0;
      rd_busy <= 1'b0;
      rd_tail <= 1'b0;
      wr_grp  <= '0;
    end else begin
      wr_busy <= wr_go;
      rd_busy <= rd_go;
      rd_tail <= rd_busy;
      if (wr_go) wr_grp <= addr_fall;
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_go && !bwe_rise_n[l])
        mem[{addr_fall, 2'd0}][l*LANE_W +: LANE_W] <= wdata_rise[l*LANE_W +: LANE_W];
      if (wr_go && !bwe_fall_n[l])
        mem[{addr_fall, 2'd1}][l*LANE_W +: LANE_W] <= wdata_fall[l*LANE_W +: LANE_W];
      if (wr_busy && !bwe_rise_n[l])
        mem[{wr_grp, 2'd2}][l*LANE_W +: LANE_W] <= wdata_rise[l*LANE_W +: LANE_W];
      if (wr_busy && !bwe_fall_n[l])
        mem[{wr_grp, 2'd3}][l*LANE_W +: LANE_W] <= wdata_fall[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_go)
      for (int b = 0; b < BEATS; b++)
        snap[b] <= mem[{addr_rise, 2'(b)}];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_rise  <= '0;
      rdata_fall  <= '0;
      rdata_valid <= 1'b0;
    end else begin
      rdata_valid <= rd_busy || rd_tail;
      if (rd_busy) begin
        rdata_rise <= snap[0];
        rdata_fall <= snap[1];
      end else if (rd_tail) begin
        rdata_rise <= snap[2];
        rdata_fall <= snap[3];
      end else begin
        rdata_rise <= '0;
        rdata_fall <= '0;
      end
    end
  end

  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |-> ##2 rdata_valid);

  a_r5_two_beat_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata_valid) |=> rdata_valid);

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_valid |-> (rdata_rise == '0 && rdata_fall == '0));

  a_r8_valid_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata_valid) |-> $past(rd_go, 2));

  a_r3_no_back_to_back_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !wr_go);
endmodule

// File: tb/qdr_burst4_sram_test.sv
`timescale 1ns/1ps
module qdr_burst4_sram_test;
  localparam int AW = 4;
  localparam int NW = (1 << AW) * 4;

  logic clk = 0, rst_n = 0;
  logic rd_sel_n = 1, wr_sel_n = 1;
  logic [AW-1:0] addr_rise = '0, addr_fall = '0;
  logic [35:0] wdata_rise = '0, wdata_fall = '0;
  logic [3:0] bwe_rise_n = '1, bwe_fall_n = '1;
  logic [35:0] rdata_rise, rdata_fall;
  logic rdata_valid;

  qdr_burst4_sram #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .addr_rise(addr_rise), .addr_fall(addr_fall),
    .wdata_rise(wdata_rise), .wdata_fall(wdata_fall),
    .bwe_rise_n(bwe_rise_n), .bwe_fall_n(bwe_fall_n),
    .rdata_rise(rdata_rise), .rdata_fall(rdata_fall), .rdata_valid(rdata_valid));

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  string tag = "R10";

  logic [35:0] mm [NW];
  logic [35:0] ms [4];
  logic m_rbusy = 0, m_tail = 0, m_wbusy = 0;
  logic [AW-1:0] m_wa = '0;
  logic e_v = 0;
  logic [35:0] e_r = '0, e_f = '0;

  function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] nw, logic [3:0] bn);
    logic [35:0] res = old;
    for (int l = 0; l < 4; l++) if (!bn[l]) res[l*9 +: 9] = nw[l*9 +: 9];
    return res;
  endfunction

  function automatic logic [35:0] rnd36();
    return {4'($urandom), 32'($urandom)};
  endfunction

  task automatic check_out();
    nchk++;
    if (rdata_valid !== e_v || rdata_rise !== e_r || rdata_fall !== e_f) begin
      nfail++;
      $display("FAIL %s: got v=%b r=%h f=%h, expected v=%b r=%h f=%h",
               tag, rdata_valid, rdata_rise, rdata_fall, e_v, e_r, e_f);
    end
  endtask

  task automatic cyc(logic rn, logic wn, logic [AW-1:0] ar, logic [AW-1:0] af,
                     logic [35:0] dr, logic [35:0] df, logic [3:0] br, logic [3:0] bf);
    logic go_r, go_w;
    rd_sel_n = rn; wr_sel_n = wn; addr_rise = ar; addr_fall = af;
    wdata_rise = dr; wdata_fall = df; bwe_rise_n = br; bwe_fall_n = bf;
    go_r = !rn && !m_rbusy;
    go_w = !wn && !m_wbusy;
    if (m_rbusy) begin e_v = 1; e_r = ms[0]; e_f = ms[1]; end
    else if (m_tail) begin e_v = 1; e_r = ms[2]; e_f = ms[3]; end
    else begin e_v = 0; e_r = '0; e_f = '0; end
    if (go_r) for (int b = 0; b < 4; b++) ms[b] = mm[ar*4 + b];
    if (go_w) begin
      mm[af*4]   = merge(mm[af*4], dr, br);
      mm[af*4+1] = merge(mm[af*4+1], df, bf);
    end
    if (m_wbusy) begin
      mm[m_wa*4+2] = merge(mm[m_wa*4+2], dr, br);
      mm[m_wa*4+3] = merge(mm[m_wa*4+3], df, bf);
    end
    m_tail = m_rbusy; m_rbusy = go_r; m_wbusy = go_w;
    if (go_w) m_wa = af;
    @(posedge clk);
    @(negedge clk);
    check_out();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1, 1, '0, '0, '0, '0, '1, '1);
  endtask

  task automatic wr_burst(logic [AW-1:0] g, logic [3:0] m0, logic [3:0] m1, logic [3:0] m2, logic [3:0] m3);
    cyc(1, 0, '0, g, rnd36(), rnd36(), m0, m1);
    cyc(1, 1, '0, '0, rnd36(), rnd36(), m2, m3);
  endtask

  task automatic rd_burst(logic [AW-1:0] g);
    cyc(0, 1, g, '0, '0, '0, '1, '1);
    idle(3);
  endtask

  initial begin
    #200000;
    nchk++; nfail++;
    $display("FAIL watchdog: got no end, expected finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    tag = "R10";
    check_out();

    tag = "R2";
    for (int g = 0; g < (1 << AW); g++) wr_burst(AW'(g), '0, '0, '0, '0);
    tag = "R5";
    for (int g = 0; g < (1 << AW); g++) rd_burst(AW'(g));

    tag = "R4";
    wr_burst(4'd3, 4'b1110, 4'b0111, 4'b1010, 4'b0101);
    wr_burst(4'd5, 4'b1111, 4'b0000, 4'b1101, 4'b1011);
    rd_burst(4'd3);
    rd_burst(4'd5);

    tag = "R3";
    for (int i = 0; i < 6; i++) cyc(1, 0, '0, AW'(i + 7), rnd36(), rnd36(), '0, '0);
    idle(1);
    for (int g = 7; g < 13; g++) rd_burst(AW'(g));

    tag = "R6";
    for (int i = 0; i < 7; i++) cyc(0, 1, AW'(i), '0, '0, '0, '1, '1);
    idle(3);

    tag = "R9";
    for (int i = 0; i < 8; i++) cyc(1, 1, '0, AW'(i), rnd36(), rnd36(), '0, '0);
    for (int g = 0; g < 8; g++) rd_burst(AW'(g));

    tag = "R7";
    cyc(0, 0, 4'd9, 4'd9, rnd36(), rnd36(), '0, '0);
    cyc(1, 1, '0, '0, rnd36(), rnd36(), '0, '0);
    idle(2);
    cyc(1, 0, '0, 4'd2, rnd36(), rnd36(), '0, '0);
    cyc(0, 1, 4'd2, '0, rnd36(), rnd36(), '0, '0);
    idle(3);
    rd_burst(4'd9);
    rd_burst(4'd2);

    tag = "R8";
    cyc(0, 1, 4'd1, '0, '0, '0, '1, '1);
    idle(5);
    cyc(0, 1, 4'd4, '0, '0, '0, '1, '1);
    cyc(1, 1, '0, '0, '0, '0, '1, '1);
    cyc(0, 1, 4'd6, '0, '0, '0, '1, '1);
    idle(5);

    tag = "R1";
    for (int i = 0; i < 4000; i++)
      cyc(($urandom % 3) == 0 ? 1'b0 : 1'b1, ($urandom % 3) == 0 ? 1'b0 : 1'b1,
          AW'($urandom), AW'($urandom), rnd36(), rnd36(), 4'($urandom), 4'($urandom));
    idle(4);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule